// File: doc/BRIEF.md
# Self-Centering Bit-Serial Elastic Buffer

This block passes a serial bit stream from one timing domain to another when both sides are strobes sampled by a single system clock. The writer may arrive in bursts and the reader may be a gapped strobe at a different nominal rate. Each bit taken in on a write strobe leaves on a later read strobe in the same order. The default storage is 80 bits, so the buffer can absorb a phase offset of up to 40 bit periods in either direction.

Two controls keep the read side a safe distance from the write side. The centering control sets the read position exactly half the buffer behind the write position. It acts once, in the first cycle after reset or on a one-cycle request, and then goes idle. The limit control watches the fill level. Near the full end it inserts an extra read in a cycle with no read strobe. Near the empty end it holds back one read strobe. With the limit control off, a true overflow or underflow sets a sticky error flag, and the data slips instead.

Top module: `elastic_store`

## Requirements
- R1: While reset is asserted and in the first cycle after it (when centering is disabled), `fill_lvl`, `dout`, `ovf_flag` and `unf_flag` are all 0, and every storage bit reads back as 0.
- R2: Bits leave in the order they were written. `dout` takes the oldest stored bit at the clock edge that samples an accepted read, and keeps its value otherwise.
- R3: `fill_lvl` equals accepted writes minus accepted reads. Its range is 0 to DEPTH, and outside centering it changes by at most one per cycle.
- R4: When `cent_en` is high and `cent_req` is high for one cycle, the read position is set CENTER (DEPTH/2) bits behind the write position after that cycle's write. `fill_lvl` becomes CENTER, a read strobe in that cycle is ignored, and `dout` keeps its value.
- R5: If `cent_en` is high in the first clock cycle after reset is released, centering happens in that cycle as described in R4, with no request. Centering then stays idle until the next request.
- R6: While `cent_en` is low, `cent_req` has no effect.
- R7: With `limit_en` high, `fill_lvl` at DEPTH-1 or more and `rd_en` low, one extra read is performed in that cycle.
- R8: With `limit_en` high, `fill_lvl` at 1 or less and `rd_en` high, the read strobe is held back and `dout` keeps its previous bit.
- R9: While `limit_en` is high, neither `ovf_flag` nor `unf_flag` is newly set.
- R10: With `limit_en` low, a write at `fill_lvl` = DEPTH with no accepted read overwrites the oldest bit and drops it. `fill_lvl` stays at DEPTH and `ovf_flag` is set.
- R11: With `limit_en` low, a read strobe at `fill_lvl` = 0 leaves `dout` and `fill_lvl` unchanged and sets `unf_flag`.
- R12: `ovf_flag` and `unf_flag` stay set until `flag_clr` is high. If a new error occurs in the same cycle as `flag_clr`, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe; stores `din` |
| din | input | 1 | Serial input bit |
| rd_en | input | 1 | Read strobe |
| dout | output | 1 | Serial output bit, registered |
| cent_en | input | 1 | Enables the centering control |
| limit_en | input | 1 | Enables the limit control |
| cent_req | input | 1 | One-cycle request to re-center |
| fill_lvl | output | $clog2(DEPTH+1) | Number of stored unread bits |
| ovf_flag | output | 1 | Sticky overflow error |
| unf_flag | output | 1 | Sticky underflow error |
| flag_clr | input | 1 | Clears both sticky flags |

## Verification
The checker assumes that strobes and controls are stable at each sampling edge. It also assumes `limit_en` is held for the whole cycle it governs, because the claim that no flag is set while the limit control is on refers to the value seen at that edge. The bench drives every input on the falling edge and samples on the next falling edge, so each input value covers exactly one rising edge. Random stimulus keeps read and write densities close. Long windows with the limit control off drive the buffer into both error conditions, and long windows with it on must keep both flags quiet.

// File: rtl/es_pkg.sv
package es_pkg;

  // Advance a pointer by one position in a ring of size depth.
  function automatic int unsigned ring_inc(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Step a pointer k positions backwards in a ring of size depth (k <= depth).
  function automatic int unsigned ring_back(int unsigned p, int unsigned k,
                                            int unsigned depth);
    return (p >= k) ? p - k : p + depth - k;
  endfunction

endpackage

// File: rtl/es_limit.sv
module es_limit #(
  parameter int DEPTH = 80,
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic          limit_en,
  input  logic          rd_en,
  input  logic [FW-1:0] fill,
  output logic          nudge_extra,
  output logic          nudge_hold
);
  logic near_full;
  logic near_empty;

  always_comb begin
    near_full   = fill >= FW'(DEPTH - 1);
    near_empty  = fill <= FW'(1);
    nudge_extra = limit_en && near_full && !rd_en;
    nudge_hold  = limit_en && near_empty && rd_en;
  end
endmodule

// File: rtl/es_store.sv
module es_store #(
  parameter int DEPTH = 80,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_do,
  input  logic [PW-1:0] wr_ptr,
  input  logic          wr_bit,
  input  logic          rd_do,
  input  logic [PW-1:0] rd_ptr,
  output logic          rd_bit
);
  logic [DEPTH-1:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               cells[g] <= 1'b0;
      else if (wr_do && wr_ptr == PW'(g))       cells[g] <= wr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_bit <= 1'b0;
    else if (rd_do) rd_bit <= cells[rd_ptr];
  end
endmodule

// File: rtl/es_ctrl.sv
module es_ctrl
  import es_pkg::*;
#(
  parameter int DEPTH = 80,
  localparam int PW = $clog2(DEPTH),
  localparam int FW = $clog2(DEPTH + 1),
  localparam int CENTER = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          cent_en,
  input  logic          cent_req,
  input  logic          flag_clr,
  input  logic          nudge_extra,
  input  logic          nudge_hold,
  output logic          cent_act,
  output logic          wr_do,
  output logic          rd_do,
  output logic          ovf_ev,
  output logic          unf_ev,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [FW-1:0] fill,
  output logic          ovf_flag,
  output logic          unf_flag
);
  logic          boot;
  logic          rd_try;
  logic [PW-1:0] wr_nxt;
  logic [PW-1:0] rd_nxt;
  logic [FW-1:0] fill_nxt;

  always_comb begin
    cent_act = cent_en && (cent_req || boot);
    rd_try   = (rd_en && !nudge_hold) || nudge_extra;
    unf_ev   = !cent_act && rd_try && fill == '0;
    rd_do    = !cent_act && rd_try && fill != '0;
    wr_do    = wr_en;
    ovf_ev   = !cent_act && wr_en && fill == FW'(DEPTH) && !rd_do;

    wr_nxt = wr_do ? PW'(ring_inc(int'(wr_ptr), DEPTH)) : wr_ptr;

    if (cent_act)
      rd_nxt = PW'(ring_back(int'(wr_nxt), CENTER, DEPTH));
    else if (rd_do || ovf_ev)
      rd_nxt = PW'(ring_inc(int'(rd_ptr), DEPTH));
    else
      rd_nxt = rd_ptr;

    if (cent_act)              fill_nxt = FW'(CENTER);
    else if (ovf_ev)           fill_nxt = fill;
    else if (wr_do && !rd_do)  fill_nxt = fill + FW'(1);
    else if (!wr_do && rd_do)  fill_nxt = fill - FW'(1);
    else                       fill_nxt = fill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot     <= 1'b1;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill     <= '0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      boot     <= 1'b0;
      wr_ptr   <= wr_nxt;
      rd_ptr   <= rd_nxt;
      fill     <= fill_nxt;
      ovf_flag <= ovf_ev || (ovf_flag && !flag_clr);
      unf_flag <= unf_ev || (unf_flag && !flag_clr);
    end
  end
endmodule

// File: rtl/elastic_store.sv
module elastic_store #(
  parameter int DEPTH = 80,
  localparam int PW = $clog2(DEPTH),
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          din,
  input  logic          rd_en,
  output logic          dout,
  input  logic          cent_en,
  input  logic          limit_en,
  input  logic          cent_req,
  output logic [FW-1:0] fill_lvl,
  output logic          ovf_flag,
  output logic          unf_flag,
  input  logic          flag_clr
);
  logic          nudge_extra;
  logic          nudge_hold;
  logic          cent_act;
  logic          wr_do;
  logic          rd_do;
  logic          ovf_ev;
  logic          unf_ev;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  es_limit #(.DEPTH(DEPTH)) u_limit (
    .limit_en   (limit_en),
    .rd_en      (rd_en),
    .fill       (fill_lvl),
    .nudge_extra(nudge_extra),
    .nudge_hold (nudge_hold)
  );

  es_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .cent_en    (cent_en),
    .cent_req   (cent_req),
    .flag_clr   (flag_clr),
    .nudge_extra(nudge_extra),
    .nudge_hold (nudge_hold),
    .cent_act   (cent_act),
    .wr_do      (wr_do),
    .rd_do      (rd_do),
    .ovf_ev     (ovf_ev),
    .unf_ev     (unf_ev),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .fill       (fill_lvl),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag)
  );

  es_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_do (wr_do),
    .wr_ptr(wr_ptr),
    .wr_bit(din),
    .rd_do (rd_do),
    .rd_ptr(rd_ptr),
    .rd_bit(dout)
  );
endmodule

// File: rtl/es_checker.sv
module es_checker #(
  parameter int DEPTH = 80,
  localparam int FW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          limit_en,
  input logic          cent_en,
  input logic          flag_clr,
  input logic [FW-1:0] fill_lvl,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic          cent_act,
  input logic          nudge_extra,
  input logic          nudge_hold,
  input logic          rd_do,
  input logic          dout
);
  p_fill_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_lvl <= FW'(DEPTH));

  p_fill_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cent_act |=> (fill_lvl == $past(fill_lvl) || fill_lvl == $past(fill_lvl) + FW'(1)
                   || fill_lvl == $past(fill_lvl) - FW'(1)));

  p_dout_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_do |=> $stable(dout));

  p_center_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cent_act |=> fill_lvl == FW'(DEPTH / 2));

  p_center_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cent_en |-> !cent_act);

  p_extra_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nudge_extra && !cent_act |-> rd_do);

  p_hold_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nudge_hold |=> $stable(dout));

  p_nudge_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nudge_extra, nudge_hold}));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    limit_en |=> !$rose(ovf_flag));

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    limit_en |=> !$rose(unf_flag));

  p_sticky_ovf_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !flag_clr |=> ovf_flag);

  p_sticky_unf_r12: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag && !flag_clr |=> unf_flag);
endmodule

bind elastic_store es_checker #(.DEPTH(DEPTH)) u_es_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .limit_en   (limit_en),
  .cent_en    (cent_en),
  .flag_clr   (flag_clr),
  .fill_lvl   (fill_lvl),
  .ovf_flag   (ovf_flag),
  .unf_flag   (unf_flag),
  .cent_act   (cent_act),
  .nudge_extra(nudge_extra),
  .nudge_hold (nudge_hold),
  .rd_do      (rd_do),
  .dout       (dout)
);

// File: tb/test_elastic_store.sv
`timescale 1ns/1ps
module test_elastic_store;
  localparam int D  = 80;
  localparam int C  = D / 2;
  localparam int FW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, din = 0, rd_en = 0, cent_en = 0, limit_en = 0, cent_req = 0, flag_clr = 0;
  logic dout, ovf_flag, unf_flag;
  logic [FW-1:0] fill_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // independent reference state
  bit m_mem [D];
  int m_wp, m_rp, m_cnt;
  bit m_dout, m_ovf, m_unf, m_boot;

  always #2 clk = ~clk;

  elastic_store #(.DEPTH(D)) i_elastic_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .rd_en(rd_en),
    .dout(dout), .cent_en(cent_en), .limit_en(limit_en), .cent_req(cent_req),
    .fill_lvl(fill_lvl), .ovf_flag(ovf_flag), .unf_flag(unf_flag), .flag_clr(flag_clr)
  );

  function automatic int step_fwd(int p);
    return (p + 1) % D;
  endfunction

  function automatic int step_back(int p, int k);
    return (p - k + D) % D;
  endfunction

  task automatic model_reset();
    foreach (m_mem[i]) m_mem[i] = 0;
    m_wp = 0; m_rp = 0; m_cnt = 0;
    m_dout = 0; m_ovf = 0; m_unf = 0; m_boot = 1;
  endtask

  task automatic model_step();
    bit centre, extra, hold, want, rd_ok, under, over;
    centre = cent_en && (cent_req || m_boot);
    m_boot = 0;
    if (flag_clr) begin m_ovf = 0; m_unf = 0; end
    if (centre) begin
      if (wr_en) begin m_mem[m_wp] = din; m_wp = step_fwd(m_wp); end
      m_rp  = step_back(m_wp, C);
      m_cnt = C;
      return;
    end
    extra = limit_en && (m_cnt >= D - 1) && !rd_en;
    hold  = limit_en && (m_cnt <= 1) && rd_en;
    want  = (rd_en && !hold) || extra;
    under = want && m_cnt == 0;
    rd_ok = want && m_cnt != 0;
    over  = wr_en && m_cnt == D && !rd_ok;
    if (under) m_unf = 1;
    if (rd_ok) begin m_dout = m_mem[m_rp]; m_rp = step_fwd(m_rp); end
    if (over)  begin m_ovf = 1; m_rp = step_fwd(m_rp); end
    if (wr_en) begin m_mem[m_wp] = din; m_wp = step_fwd(m_wp); end
    if (!over) m_cnt = m_cnt + int'(wr_en) - int'(rd_ok);
  endtask

  task automatic check(string tag);
    n_chk++;
    if (dout !== m_dout || int'(fill_lvl) != m_cnt || ovf_flag !== m_ovf || unf_flag !== m_unf) begin
      n_bad++;
      $display("FAIL %s: dout=%0b fill=%0d ovf=%0b unf=%0b expected dout=%0b fill=%0d ovf=%0b unf=%0b",
               tag, dout, fill_lvl, ovf_flag, unf_flag, m_dout, m_cnt, m_ovf, m_unf);
    end
  endtask

  task automatic check_val(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: inputs already driven; model and compare at the falling edge
  task automatic cyc(bit w, bit d, bit r, string tag);
    wr_en = w; din = d; rd_en = r;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag);
    cent_req = 0; flag_clr = 0;
  endtask

  task automatic do_reset(bit ce);
    @(negedge clk);
    rst_n = 0; cent_en = ce; wr_en = 0; rd_en = 0; cent_req = 0; flag_clr = 0;
    model_reset();
    @(negedge clk);
    check("R1");
    rst_n = 1;
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5eed_0123);
    model_reset();

    // R1: reset state, centering off
    do_reset(0);
    cyc(0, 0, 0, "R1");
    check_val("R1", int'(fill_lvl), 0);

    // R2/R3: write a pattern, read back in order
    for (int i = 0; i < 12; i++) cyc(1, bit'((i * 5) % 3 == 1), 0, "R3");
    check_val("R3", int'(fill_lvl), 12);
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, "R2");
    cyc(1, 1, 1, "R2");

    // R11: read at empty without limit
    cyc(0, 0, 1, "R11");
    cyc(0, 0, 1, "R11");
    check_val("R11", int'(unf_flag), 1);
    // R12: clear and set in same cycle keeps flag, then plain clear
    flag_clr = 1; cyc(0, 0, 1, "R12");
    check_val("R12", int'(unf_flag), 1);
    flag_clr = 1; cyc(0, 0, 0, "R12");
    check_val("R12", int'(unf_flag), 0);

    // R10: fill completely, then overflow
    for (int i = 0; i < D + 3; i++) cyc(1, bit'(i % 2), 0, "R10");
    check_val("R10", int'(fill_lvl), D);
    check_val("R10", int'(ovf_flag), 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, "R10");

    // R7: limit at near-full inserts extra reads
    limit_en = 1;
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, "R7");
    check_val("R7", int'(fill_lvl), D - 1);
    // R8: drain to near-empty, then read strobes are held back
    for (int i = 0; i < D; i++) cyc(0, 0, 1, "R8");
    check_val("R8", int'(fill_lvl), 1);
    cyc(0, 0, 1, "R8");
    cyc(1, 1, 1, "R9");
    limit_en = 0;

    // R6: request ignored while centering disabled
    cent_req = 1; cyc(1, 0, 0, "R6");
    // R4: centering on request
    cent_en = 1; cent_req = 1; cyc(1, 1, 1, "R4");
    check_val("R4", int'(fill_lvl), C);
    cyc(0, 0, 1, "R4");

    // R5: centering right after reset
    do_reset(1);
    cyc(1, 1, 0, "R5");
    check_val("R5", int'(fill_lvl), C);
    cyc(0, 0, 1, "R5");

    // random mix with rare control changes
    for (int blk = 0; blk < 40; blk++) begin
      int wp_, rp_;
      limit_en = bit'($urandom_range(0, 1));
      cent_en  = bit'($urandom_range(0, 1));
      wp_ = $urandom_range(35, 65);
      rp_ = $urandom_range(35, 65);
      for (int i = 0; i < 400; i++) begin
        cent_req = ($urandom_range(0, 199) == 0);
        flag_clr = ($urandom_range(0, 99) == 0);
        cyc(bit'($urandom_range(0, 99) < wp_), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 99) < rp_), limit_en ? "R9" : "R3");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule